// File: doc/BRIEF.md
# Single-Cycle Six-Instruction Processor Core

This block is a 32-bit processor core that completes one instruction on every rising clock edge. In a single pass it fetches the instruction that the program counter points at, decodes it into a small control word, reads two source registers, runs the adder-based ALU, and optionally accesses data memory. It then commits the register or memory write and the next program counter together at the edge. Six operations are supported: register add, add with a sign-extended 16-bit immediate, word load, word store, branch when two registers are equal, and absolute jump.

The instruction and data memories are small word-addressed arrays inside the core. Both are filled through a load port, normally while reset is held. A set of observation outputs shows the current program counter and instruction, the register write that the next edge will commit, and the data memory write that the next edge will commit. A testbench can use these outputs to follow architectural state against a reference model.

Top module: `sc_core`

## Requirements
- R1: A synchronous active-high reset, sampled at a rising edge, sets the program counter to 0 and clears every register. Reads after reset return 0.
- R2: Instruction format: opcode [31:26], rs [25:21], rt [20:16], rd [15:11], function [5:0], immediate [15:0], jump field [25:0]. Opcode 0x00 with function 0x20 writes rs+rt into rd, and the next program counter is the current one plus 4.
- R3: Opcode 0x0F writes rs plus the immediate, with bit 15 replicated into bits 31:16, into rt.
- R4: Opcode 0x23 writes into rt the data word at address rs plus the sign-extended immediate. The data memory is indexed by address bits [MEM_AW+1:2], so address bits 1:0 have no effect.
- R5: Opcode 0x2A writes the rt value into data memory at rs plus the sign-extended immediate, and writes no register.
- R6: Opcode 0x04 compares rs and rt. When they are equal, the next program counter is PC+4 plus the sign-extended immediate shifted left by 2, which may be a backward step. When they differ, it is PC+4.
- R7: Opcode 0x02 sets the next program counter to four zero bits, then the 26-bit jump field, then two zero bits.
- R8: Register 0 always reads as zero. An instruction whose destination is register 0 changes no register and raises no write strobe.
- R9: Any other opcode, and opcode 0x00 with a function other than 0x20, writes neither a register nor memory, and the next program counter is PC+4.
- R10: The register write strobe is high exactly in the cycles whose edge will change a nonzero register. In those cycles it shows that register's index and the value being written. The store strobe likewise shows the store address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| ld_en | input | 1 | Load one memory word this edge |
| ld_sel | input | 1 | Load target: 1 instruction memory, 0 data memory |
| ld_addr | input | MEM_AW | Word index to load |
| ld_data | input | 32 | Word to load |
| dbg_pc | output | 32 | Current program counter |
| dbg_insn | output | 32 | Instruction being executed |
| dbg_rf_we | output | 1 | A nonzero register is written at the next edge |
| dbg_rf_addr | output | 5 | Destination register index |
| dbg_rf_data | output | 32 | Value written to the register |
| dbg_dm_we | output | 1 | Data memory is written at the next edge |
| dbg_dm_addr | output | 32 | Byte address of the data access |
| dbg_dm_data | output | 32 | Store data |

## Verification
Within a cycle, every write strobe, address and data output is a combinational function of the current program counter and the register state. The bench therefore compares them in the same cycle, at the falling edge, before the edge that commits them. The effect of that edge appears one cycle later: the new program counter, and the new register or memory contents, which later reads and the next write values expose. The behavioural model advances its own state exactly once per rising edge, so each comparison lands in the cycle where the result is due. A taken branch or a jump is checked through the program counter one cycle after the branch instruction appears.

// File: rtl/sc_pkg.sv
package sc_pkg;

    localparam int XLEN    = 32;
    localparam int NREGS   = 32;
    localparam int REG_AW  = $clog2(NREGS);

    localparam logic [5:0] OP_RTYPE = 6'h00;
    localparam logic [5:0] FN_ADD   = 6'h20;
    localparam logic [5:0] OP_ADDI  = 6'h0F;
    localparam logic [5:0] OP_LW    = 6'h23;
    localparam logic [5:0] OP_SW    = 6'h2A;
    localparam logic [5:0] OP_BEQ   = 6'h04;
    localparam logic [5:0] OP_J     = 6'h02;

    typedef struct packed {
        logic br;         // conditional branch on equality
        logic jp;         // absolute jump
        logic alu_b_imm;  // second operand is the immediate
        logic alu_cmp;    // ALU subtracts for compare
        logic dm_we;      // data memory write
        logic rf_we;      // register write
        logic rf_dst_rt;  // destination is rt (else rd)
        logic rf_wd_mem;  // write data from memory (else ALU)
    } ctrl_t;

endpackage

// File: rtl/sc_decode.sv
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] fn,
    output ctrl_t      ctrl
);

    always_comb begin
        ctrl = '0;
        case (op)
            OP_RTYPE: begin
                if (fn == FN_ADD) begin
                    ctrl.rf_we = 1'b1;
                end
            end
            OP_ADDI: begin
                ctrl.alu_b_imm = 1'b1;
                ctrl.rf_we     = 1'b1;
                ctrl.rf_dst_rt = 1'b1;
            end
            OP_LW: begin
                ctrl.alu_b_imm = 1'b1;
                ctrl.rf_we     = 1'b1;
                ctrl.rf_dst_rt = 1'b1;
                ctrl.rf_wd_mem = 1'b1;
            end
            OP_SW: begin
                ctrl.alu_b_imm = 1'b1;
                ctrl.dm_we     = 1'b1;
            end
            OP_BEQ: begin
                ctrl.br      = 1'b1;
                ctrl.alu_cmp = 1'b1;
            end
            OP_J: begin
                ctrl.jp = 1'b1;
            end
            default: ctrl = '0;
        endcase
    end

endmodule

// File: rtl/sc_alu.sv
module sc_alu #(
    parameter int W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cmp,
    output logic [W-1:0] y,
    output logic         eq
);

    logic [W-1:0] sum;
    logic [W-1:0] diff;

    always_comb begin
        sum  = a + b;
        diff = a - b;
        y    = cmp ? diff : sum;
        eq   = (diff == '0);
    end

endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
    parameter int W  = 32,
    parameter int N  = 32,
    localparam int AW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_a,
    input  logic [AW-1:0] ra_b,
    output logic [W-1:0]  rd_a,
    output logic [W-1:0]  rd_b,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd
);

    logic [W-1:0] regs_d [N];
    logic [W-1:0] regs_q [N];
    logic [N-1:0] hit;

    // one-hot write select, entry 0 never selected
    for (genvar g = 0; g < N; g++) begin : g_sel
        if (g == 0) begin : g_zero
            assign hit[g] = 1'b0;
        end else begin : g_live
            assign hit[g] = we && (wa == AW'(g));
        end
    end

    always_comb begin
        for (int i = 0; i < N; i++) begin
            regs_d[i] = hit[i] ? wd : regs_q[i];
            if (rst) begin
                regs_d[i] = '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        regs_q <= regs_d;
    end

    assign rd_a = (ra_a == '0) ? '0 : regs_q[ra_a];
    assign rd_b = (ra_b == '0) ? '0 : regs_q[ra_b];

endmodule

// File: rtl/sc_core.sv
module sc_core
    import sc_pkg::*;
#(
    parameter int MEM_AW = 6,
    localparam int DEPTH = 1 << MEM_AW
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ld_en,
    input  logic              ld_sel,
    input  logic [MEM_AW-1:0] ld_addr,
    input  logic [XLEN-1:0]   ld_data,
    output logic [XLEN-1:0]   dbg_pc,
    output logic [XLEN-1:0]   dbg_insn,
    output logic              dbg_rf_we,
    output logic [REG_AW-1:0] dbg_rf_addr,
    output logic [XLEN-1:0]   dbg_rf_data,
    output logic              dbg_dm_we,
    output logic [XLEN-1:0]   dbg_dm_addr,
    output logic [XLEN-1:0]   dbg_dm_data
);

    typedef struct packed {
        logic [XLEN-1:0] pc;
    } state_t;

    state_t st_d, st_q;

    logic [XLEN-1:0] imem_q [DEPTH];
    logic [XLEN-1:0] dmem_q [DEPTH];

    logic [XLEN-1:0]   insn;
    ctrl_t             ctrl;
    logic [XLEN-1:0]   sext;
    logic [XLEN-1:0]   src_a, src_b, alu_b, alu_y;
    logic              alu_eq;
    logic [REG_AW-1:0] dst;
    logic [XLEN-1:0]   wd;
    logic              rf_we_eff;
    logic              dm_we_eff;
    logic [XLEN-1:0]   pc4, br_tgt, jmp_tgt;

    assign insn = imem_q[st_q.pc[MEM_AW+1:2]];

    sc_decode u_dec (
        .op   (insn[31:26]),
        .fn   (insn[5:0]),
        .ctrl (ctrl)
    );

    sc_regfile #(.W(XLEN), .N(NREGS)) u_rf (
        .clk  (clk),
        .rst  (rst),
        .ra_a (insn[25:21]),
        .ra_b (insn[20:16]),
        .rd_a (src_a),
        .rd_b (src_b),
        .we   (rf_we_eff),
        .wa   (dst),
        .wd   (wd)
    );

    sc_alu #(.W(XLEN)) u_alu (
        .a   (src_a),
        .b   (alu_b),
        .cmp (ctrl.alu_cmp),
        .y   (alu_y),
        .eq  (alu_eq)
    );

    always_comb begin
        sext      = {{16{insn[15]}}, insn[15:0]};
        alu_b     = ctrl.alu_b_imm ? sext : src_b;
        dst       = ctrl.rf_dst_rt ? insn[20:16] : insn[15:11];
        wd        = ctrl.rf_wd_mem ? dmem_q[alu_y[MEM_AW+1:2]] : alu_y;
        rf_we_eff = ctrl.rf_we && !rst;
        dm_we_eff = ctrl.dm_we && !rst;

        pc4     = st_q.pc + XLEN'(4);
        br_tgt  = pc4 + {sext[XLEN-3:0], 2'b00};
        jmp_tgt = {4'b0000, insn[25:0], 2'b00};

        st_d = st_q;
        if (ctrl.jp) begin
            st_d.pc = jmp_tgt;
        end else if (ctrl.br && alu_eq) begin
            st_d.pc = br_tgt;
        end else begin
            st_d.pc = pc4;
        end
        if (rst) begin
            st_d.pc = '0;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (ld_en && ld_sel) begin
            imem_q[ld_addr] <= ld_data;
        end
    end

    always_ff @(posedge clk) begin
        if (ld_en && !ld_sel) begin
            dmem_q[ld_addr] <= ld_data;
        end else if (dm_we_eff) begin
            dmem_q[alu_y[MEM_AW+1:2]] <= src_b;
        end
    end

    assign dbg_pc      = st_q.pc;
    assign dbg_insn    = insn;
    assign dbg_rf_we   = rf_we_eff && (dst != '0);
    assign dbg_rf_addr = dst;
    assign dbg_rf_data = wd;
    assign dbg_dm_we   = dm_we_eff;
    assign dbg_dm_addr = alu_y;
    assign dbg_dm_data = src_b;

endmodule

// File: rtl/sc_core_chk.sv
module sc_core_chk (
    input logic        clk,
    input logic        rst,
    input logic [31:0] dbg_pc,
    input logic [31:0] dbg_insn,
    input logic        dbg_rf_we,
    input logic [4:0]  dbg_rf_addr,
    input logic        dbg_dm_we
);

    logic [5:0] op;
    logic [5:0] fn;
    logic       known;

    assign op    = dbg_insn[31:26];
    assign fn    = dbg_insn[5:0];
    assign known = (op == 6'h00 && fn == 6'h20) || op == 6'h0F || op == 6'h23 ||
                   op == 6'h2A || op == 6'h04 || op == 6'h02;

    p_reset_pc_r1: assert property (@(posedge clk) rst |=> dbg_pc == 32'd0);

    p_add_step_r2: assert property (@(posedge clk) disable iff (rst)
        (op == 6'h00 && fn == 6'h20) |=> dbg_pc == $past(dbg_pc) + 32'd4);

    p_store_no_reg_r5: assert property (@(posedge clk) disable iff (rst)
        dbg_dm_we |-> !dbg_rf_we);

    p_jump_target_r7: assert property (@(posedge clk) disable iff (rst)
        op == 6'h02 |=> dbg_pc == {4'b0000, $past(dbg_insn[25:0]), 2'b00});

    p_reg0_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        dbg_rf_we |-> dbg_rf_addr != 5'd0);

    p_unknown_nop_r9: assert property (@(posedge clk) disable iff (rst)
        !known |-> (!dbg_rf_we && !dbg_dm_we));

    p_unknown_step_r9: assert property (@(posedge clk) disable iff (rst)
        !known |=> dbg_pc == $past(dbg_pc) + 32'd4);

    p_pc_aligned_r6: assert property (@(posedge clk) disable iff (rst)
        dbg_pc[1:0] == 2'b00);

endmodule

bind sc_core sc_core_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .dbg_pc      (dbg_pc),
    .dbg_insn    (dbg_insn),
    .dbg_rf_we   (dbg_rf_we),
    .dbg_rf_addr (dbg_rf_addr),
    .dbg_dm_we   (dbg_dm_we)
);

// File: tb/sc_core_tb_top.sv
module sc_core_tb_top;

    localparam int AW    = 6;
    localparam int WORDS = 1 << AW;
    localparam int RUN   = 60;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          ld_en = 1'b0;
    logic          ld_sel = 1'b0;
    logic [AW-1:0] ld_addr = '0;
    logic [31:0]   ld_data = '0;
    logic [31:0]   dbg_pc, dbg_insn, dbg_rf_data, dbg_dm_addr, dbg_dm_data;
    logic [4:0]    dbg_rf_addr;
    logic          dbg_rf_we, dbg_dm_we;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [31:0] m_im [WORDS];
    logic [31:0] m_dm [WORDS];
    logic [31:0] m_rf [32];
    logic [31:0] m_pc;

    always #10 clk = ~clk;

    sc_core #(.MEM_AW(AW)) dut_i (
        .clk         (clk),
        .rst         (rst),
        .ld_en       (ld_en),
        .ld_sel      (ld_sel),
        .ld_addr     (ld_addr),
        .ld_data     (ld_data),
        .dbg_pc      (dbg_pc),
        .dbg_insn    (dbg_insn),
        .dbg_rf_we   (dbg_rf_we),
        .dbg_rf_addr (dbg_rf_addr),
        .dbg_rf_data (dbg_rf_data),
        .dbg_dm_we   (dbg_dm_we),
        .dbg_dm_addr (dbg_dm_addr),
        .dbg_dm_data (dbg_dm_data)
    );

    function automatic logic [31:0] enc_r(int rs, int rt, int rd, logic [5:0] fn);
        return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, int imm);
        return {op, 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    function automatic logic [31:0] enc_j(int tgt);
        return {6'h02, 26'(tgt)};
    endfunction

    function automatic string tag_of(logic [31:0] i);
        case (i[31:26])
            6'h00:   return (i[5:0] == 6'h20) ? "R2" : "R9";
            6'h0F:   return "R3";
            6'h23:   return "R4";
            6'h2A:   return "R5";
            6'h04:   return "R6";
            6'h02:   return "R7";
            default: return "R9";
        endcase
    endfunction

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic load_word(input bit to_imem, input int idx, input logic [31:0] val);
        @(negedge clk);
        ld_en   = 1'b1;
        ld_sel  = to_imem;
        ld_addr = AW'(idx);
        ld_data = val;
    endtask

    // one reference step: compare the current cycle, then advance the model
    task automatic step_and_check(input int cyc);
        logic [31:0] i, a, b, sx, sum, nxt, addr;
        logic [5:0]  op;
        bit          wr, st;
        int          dst;
        string       t, wt;
        i   = m_im[m_pc[AW+1:2]];
        op  = i[31:26];
        a   = m_rf[i[25:21]];
        b   = m_rf[i[20:16]];
        sx  = {{16{i[15]}}, i[15:0]};
        nxt = m_pc + 32'd4;
        wr  = 1'b0;
        st  = 1'b0;
        dst = 0;
        sum = 32'd0;
        addr = a + sx;
        if (op == 6'h00 && i[5:0] == 6'h20) begin
            wr = 1'b1; dst = i[15:11]; sum = a + b;
        end else if (op == 6'h0F) begin
            wr = 1'b1; dst = i[20:16]; sum = addr;
        end else if (op == 6'h23) begin
            wr = 1'b1; dst = i[20:16]; sum = m_dm[addr[AW+1:2]];
        end else if (op == 6'h2A) begin
            st = 1'b1;
        end else if (op == 6'h04) begin
            if (a == b) nxt = m_pc + 32'd4 + (sx << 2);
        end else if (op == 6'h02) begin
            nxt = {4'b0000, i[25:0], 2'b00};
        end
        t  = tag_of(i);
        wt = (wr && dst == 0) ? "R8" : "R10";
        if (cyc == 0) chk("R1", "pc after reset", dbg_pc, 32'd0);
        chk(t, "pc", dbg_pc, m_pc);
        chk(t, "insn", dbg_insn, i);
        chk(wt, "rf strobe", {31'd0, dbg_rf_we}, {31'd0, wr && dst != 0});
        if (wr && dst != 0) begin
            chk(t, "rf addr", {27'd0, dbg_rf_addr}, 32'(dst));
            chk(t, "rf data", dbg_rf_data, sum);
            if (cyc == 0) chk("R1", "cleared register read", dbg_rf_data, 32'd0);
        end
        chk(t, "store strobe", {31'd0, dbg_dm_we}, {31'd0, st});
        if (st) begin
            chk("R10", "store addr", dbg_dm_addr, addr);
            chk(t, "store data", dbg_dm_data, b);
            m_dm[addr[AW+1:2]] = b;
        end
        if (wr && dst != 0) m_rf[dst] = sum;
        m_pc = nxt;
    endtask

    initial begin
        for (int k = 0; k < WORDS; k++) begin
            m_im[k] = 32'd0;
            m_dm[k] = 32'h1000_0000 + 32'(k * 7);
        end
        m_dm[10] = 32'hCAFE_0001;
        for (int k = 0; k < 32; k++) m_rf[k] = 32'd0;
        m_pc = 32'd0;

        m_im[0]  = enc_r(1, 2, 6, 6'h20);          // reads of cleared registers
        m_im[1]  = enc_i(6'h0F, 0, 1, 5);
        m_im[2]  = enc_i(6'h0F, 0, 2, -3);          // negative immediate
        m_im[3]  = enc_r(1, 2, 3, 6'h20);
        m_im[4]  = enc_i(6'h0F, 0, 0, 7);           // write to register 0
        m_im[5]  = enc_r(0, 1, 4, 6'h20);
        m_im[6]  = enc_i(6'h2A, 0, 3, 8);           // store to word 2
        m_im[7]  = enc_i(6'h23, 0, 5, 9);           // misaligned load of word 2
        m_im[8]  = enc_i(6'h23, 0, 8, 40);          // preloaded word 10
        m_im[9]  = enc_i(6'h04, 1, 2, 5);           // not taken
        m_im[10] = enc_i(6'h04, 3, 3, 1);           // taken forward
        m_im[11] = enc_i(6'h0F, 0, 9, 99);          // skipped
        m_im[12] = 32'hFC00_0000;                   // unknown opcode
        m_im[13] = enc_r(1, 2, 10, 6'h21);          // unknown function
        m_im[14] = enc_j(20);
        m_im[20] = enc_i(6'h0F, 0, 7, 3);
        m_im[21] = enc_i(6'h0F, 7, 7, -1);
        m_im[22] = enc_i(6'h04, 7, 0, 1);
        m_im[23] = enc_i(6'h04, 0, 0, -3);          // backward branch
        m_im[24] = enc_i(6'h2A, 8, 1, -4);
        m_im[25] = enc_j(25);

        repeat (2) @(posedge clk);
        for (int k = 0; k < WORDS; k++) load_word(1'b1, k, m_im[k]);
        for (int k = 0; k < WORDS; k++) load_word(1'b0, k, m_dm[k]);
        @(negedge clk);
        ld_en = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        #1;
        for (int c = 0; c < RUN; c++) begin
            step_and_check(c);
            @(negedge clk);
            #1;
        end
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog R1 actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule